// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This block sits on the host side of a serial link to one or more delta-sigma converters. A frame starts when the converter pulls its active-low data-ready line low. The controller first passes that line through a synchronizer and a guard delay. It then drives a serial clock at a power-of-two fraction of its own clock and shifts in the converter's data line. Each 24-bit result it collects is handed out in parallel, together with the index of the channel it belongs to.

Several converters can be chained so that their results arrive back to back on one data line. The controller then reads channels × devices words per frame. Between frames the serial clock either stops low or keeps toggling, as set by a mode input; in both cases bits are captured only while a frame is open. If a new frame begins before the current one is finished, the controller reports an overrun, drops the partial frame and restarts at channel 0.

The word output is valid-only. The converter cannot be paused in the middle of a frame, so the block offers no back-pressure. The sink must accept every pulse of `word_valid_o` in the cycle it appears. `div_sel_i` and `free_run_i` must not change while a frame is in progress.

Top module: `adc_serial_reader`

## Requirements
- R1: During and after reset, with no frame open, `sclk_o` is low and `word_valid_o` and `overrun_o` are 0.
- R2: A frame starts only on a high-to-low transition of `rdy_n_i`. Holding `rdy_n_i` low after a frame has completed starts no further frame: no serial clock rising edges and no words.
- R3: The first rising edge of `sclk_o` that captures data comes at least one `clk` period after `rdy_n_i` falls.
- R4: Data is sampled at rising edges of `sclk_o`. Each word is 24 bits, and the first bit received is the word's MSB (bit 23).
- R5: With `div_sel_i` = k, `sclk_o` has a period of 2^k `clk` cycles. With k = 0, `sclk_o` is the inverse of `clk`, gated to the frame.
- R6: With `free_run_i` = 0, `sclk_o` stays low between frames. A frame produces exactly 24 × CHANS × DEVS rising edges.
- R7: With `free_run_i` = 1, `sclk_o` keeps toggling between frames. Capture still follows the frame, so every word still matches the stream that follows the ready edge.
- R8: `word_valid_o` is a one-cycle pulse per word. `word_chan_o` counts 0, 1, … up to CHANS × DEVS − 1 within a frame.
- R9: A frame holds CHANS × DEVS words. For a chain, the first word received belongs to the device nearest the controller, channel 0.
- R10: If `rdy_n_i` falls while a frame is open, `overrun_o` pulses for one cycle. The partial frame is dropped, and the new frame is read in full starting at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rdy_n_i | input | 1 | Converter data-ready, active low, asynchronous |
| sdata_i | input | 1 | Serial data from the converter (chain) |
| div_sel_i | input | SEL_W | Serial clock ratio select: period is 2^value clk cycles |
| free_run_i | input | 1 | 1: serial clock toggles between frames; 0: it stops low |
| sclk_o | output | 1 | Serial clock to the converter |
| word_data_o | output | WORD_W | Assembled result, two's complement |
| word_chan_o | output | IDX_W | Channel index of the result within the frame |
| word_valid_o | output | 1 | One-cycle strobe marking a result |
| overrun_o | output | 1 | One-cycle strobe: frame restarted before completion |

## Verification
The hardest case to reach is a ready edge that arrives in the middle of an open frame while the serial clock is divided. Whether the old frame's bits or the new frame's bits reach the result then depends on where in the clock phase the edge lands. The stimulus waits for two words of a first frame and briefly raises the ready line. It then drops the line again just after a serial clock rising edge, with the converter model reloaded with a second pattern. The full second pattern must then arrive starting at channel 0. The free-running case is aligned the same way, so that the converter model and the controller agree on which rising edge carries the first bit.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [0:0] {
    RD_IDLE  = 1'b0,
    RD_SHIFT = 1'b1
  } rd_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rdy_fall_sync.sv
module rdy_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= async_n_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             run_i,
  input  logic             restart_i,
  output logic             sclk_o,
  output logic             rise_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             sclk_q;
  logic             tick;
  logic             full_rate;

  assign full_rate = (sel_i == '0);

  always_comb begin
    half_m1 = '0;
    if (!full_rate)
      half_m1 = (CNT_W'(1) << (sel_i - SEL_W'(1))) - CNT_W'(1);
  end

  assign tick = (cnt_q == half_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (restart_i || !run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end

  // Full rate: inverted master clock, so its rising edge sits mid-bit.
  assign sclk_o = full_rate ? (run_i & ~clk) : sclk_q;
  assign rise_o = full_rate ? run_i : (run_i & ~restart_i & tick & ~sclk_q);
endmodule

// File: rtl/word_deser.sv
module word_deser #(
  parameter int WORD_W = 24,
  parameter int NWORDS = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] data_o,
  output logic [IDX_W-1:0]  chan_o,
  output logic              valid_o,
  output logic              done_o
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic [IDX_W-1:0]  word_q;
  logic              word_end;

  assign word_end = (bit_q == BIT_W'(WORD_W - 1));
  assign done_o   = sample_i & word_end & (word_q == IDX_W'(NWORDS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q    <= '0;
      bit_q   <= '0;
      word_q  <= '0;
      data_o  <= '0;
      chan_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clear_i) begin
        bit_q  <= '0;
        word_q <= '0;
      end else if (sample_i) begin
        sh_q <= {sh_q[WORD_W-2:0], bit_i};
        if (word_end) begin
          data_o  <= {sh_q[WORD_W-2:0], bit_i};
          chan_o  <= word_q;
          valid_o <= 1'b1;
          bit_q   <= '0;
          word_q  <= (word_q == IDX_W'(NWORDS - 1)) ? '0 : word_q + IDX_W'(1);
        end else begin
          bit_q <= bit_q + BIT_W'(1);
        end
      end
    end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CHANS  = 4,
  parameter int DEVS   = 2,
  parameter int SEL_W  = 3,
  parameter int SYNC_N = 2,
  localparam int NWORDS = CHANS * DEVS,
  localparam int IDX_W  = idx_width(CHANS * DEVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_n_i,
  input  logic              sdata_i,
  input  logic [SEL_W-1:0]  div_sel_i,
  input  logic              free_run_i,
  output logic              sclk_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [IDX_W-1:0]  word_chan_o,
  output logic              word_valid_o,
  output logic              overrun_o
);
  rd_state_e state_q;
  logic      start;
  logic      shifting;
  logic      rise;
  logic      sample;
  logic      done;

  assign shifting = (state_q == RD_SHIFT);
  assign sample   = shifting & rise & ~start;

  rdy_fall_sync #(.STAGES(SYNC_N)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_n_i (rdy_n_i),
    .fall_o    (start)
  );

  sclk_divider #(.SEL_W(SEL_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (div_sel_i),
    .run_i     (free_run_i | shifting),
    .restart_i (start & ~free_run_i),
    .sclk_o    (sclk_o),
    .rise_o    (rise)
  );

  word_deser #(.WORD_W(WORD_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start),
    .sample_i (sample),
    .bit_i    (sdata_i),
    .data_o   (word_data_o),
    .chan_o   (word_chan_o),
    .valid_o  (word_valid_o),
    .done_o   (done)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q   <= RD_IDLE;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= start & shifting;
      if (start)     state_q <= RD_SHIFT;
      else if (done) state_q <= RD_IDLE;
    end
endmodule

// File: rtl/adc_reader_checks.sv
module adc_reader_checks #(
  parameter int CHANS = 4,
  parameter int DEVS  = 2,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rdy_n_i,
  input logic             free_run_i,
  input logic             sclk_o,
  input logic             word_valid_o,
  input logic [IDX_W-1:0] word_chan_o,
  input logic             overrun_o,
  input logic             sample,
  input logic             shifting
);
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  p_chan_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (int'(word_chan_o) < CHANS * DEVS));

  p_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rdy_n_i) && !shifting) |=> !sample ##1 !sample);

  p_valid_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(shifting));

  p_overrun_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> !overrun_o);

  p_overrun_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> shifting);

  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run_i && $past(!free_run_i) && !shifting && $past(!shifting)) |-> !sclk_o);
endmodule

bind adc_serial_reader adc_reader_checks #(
  .CHANS (CHANS),
  .DEVS  (DEVS),
  .IDX_W (IDX_W)
) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .rdy_n_i      (rdy_n_i),
  .free_run_i   (free_run_i),
  .sclk_o       (sclk_o),
  .word_valid_o (word_valid_o),
  .word_chan_o  (word_chan_o),
  .overrun_o    (overrun_o),
  .sample       (sample),
  .shifting     (shifting)
);

// File: tb/test_adc_serial_reader.sv
`timescale 1ns/1ps
module test_adc_serial_reader;
  localparam int WORD_W = 24;
  localparam int CHANS  = 4;
  localparam int DEVS   = 2;
  localparam int SEL_W  = 3;
  localparam int NW     = CHANS * DEVS;
  localparam int TOTAL  = WORD_W * NW;
  localparam int IDX_W  = $clog2(NW);
  localparam realtime TCLK = 8.0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rdy_n = 1'b1;
  logic              sdata;
  logic [SEL_W-1:0]  div_sel = '0;
  logic              free_run = 1'b0;
  logic              sclk;
  logic [WORD_W-1:0] wdata;
  logic [IDX_W-1:0]  wchan;
  logic              wvalid;
  logic              overrun;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  adc_serial_reader #(.WORD_W(WORD_W), .CHANS(CHANS), .DEVS(DEVS), .SEL_W(SEL_W)) i_adc_serial_reader (
    .clk (clk), .rst_n (rst_n), .rdy_n_i (rdy_n), .sdata_i (sdata),
    .div_sel_i (div_sel), .free_run_i (free_run), .sclk_o (sclk),
    .word_data_o (wdata), .word_chan_o (wchan), .word_valid_o (wvalid),
    .overrun_o (overrun)
  );

  // Converter model: output changes on falling sclk, after the first rise of a frame.
  logic [TOTAL-1:0] m_stream = '0;
  logic             m_live = 1'b0;
  logic             m_armed = 1'b0;
  assign sdata = m_stream[TOTAL-1];
  always @(posedge sclk) if (m_live) m_armed <= 1'b1;
  always @(negedge sclk) if (m_armed) m_stream <= m_stream << 1;

  // Monitors
  logic [WORD_W-1:0] got_data [NW];
  int                got_chan [NW];
  int got_n = 0, valid_len = 0, valid_bad = 0, ovr_n = 0, rise_cnt = 0, per_bad = 0;
  bit track = 0, seen_first = 0;
  realtime fall_t, first_rise_t, last_rise_t, exp_per;

  always @(negedge clk) begin
    if (wvalid) begin
      if (got_n < NW) begin
        got_data[got_n] = wdata;
        got_chan[got_n] = int'(wchan);
      end
      got_n++;
      valid_len++;
      if (valid_len > 1) valid_bad++;
    end else valid_len = 0;
    if (overrun) ovr_n++;
  end

  always @(posedge sclk) begin
    rise_cnt++;
    if (track) begin
      if (!seen_first) begin
        first_rise_t = $realtime;
        seen_first = 1;
      end else if ($realtime - last_rise_t != exp_per) per_bad++;
      last_rise_t = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] pat(input int seed, input int k);
    logic [WORD_W-1:0] v;
    v = WORD_W'(seed * 7919 + k * 40503 + 17);
    if (k % 2 == 1) v[WORD_W-1] = 1'b1;
    return v;
  endfunction

  logic [WORD_W-1:0] exp_w [NW];

  task automatic drop_ready(input int seed);
    logic [TOTAL-1:0] s;
    for (int k = 0; k < NW; k++) begin
      exp_w[k] = pat(seed, k);
      s[TOTAL-1-k*WORD_W -: WORD_W] = exp_w[k];
    end
    m_stream = s;
    m_armed = 1'b0;
    m_live = 1'b1;
    got_n = 0;
    rise_cnt = 0;
    per_bad = 0;
    seen_first = 0;
    track = 1;
    fall_t = $realtime;
    rdy_n = 1'b0;
  endtask

  task automatic wait_words(input int limit);
    for (int c = 0; c < limit && got_n < NW; c++) @(posedge clk);
    repeat (4) @(posedge clk);
    #2;
    track = 0;
  endtask

  task automatic check_words(input string req);
    int bad_d = 0, bad_c = 0;
    check(got_n == NW, "R9", {req, " word count"}, got_n, NW);
    for (int k = 0; k < NW; k++) begin
      if (got_data[k] !== exp_w[k]) begin
        bad_d++;
        $display("FAIL %s word %0d: actual=%h expected=%h", req, k, got_data[k], exp_w[k]);
      end
      if (got_chan[k] != k) bad_c++;
    end
    check(bad_d == 0, req, "MSB-first word data mismatches", bad_d, 0);
    check(bad_c == 0, "R8", "channel index sequence mismatches", bad_c, 0);
    check(valid_bad == 0, "R8", "multi-cycle valid", valid_bad, 0);
  endtask

  task automatic t_reset();
    #2;
    check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    check(wvalid == 1'b0, "R1", "valid in reset", wvalid, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #3;
    check(sclk == 1'b0 && !wvalid && !overrun, "R1", "idle outputs after reset",
          {sclk, wvalid, overrun}, 0);
  endtask

  task automatic t_stop_frame(input int sel, input int seed);
    free_run = 1'b0;
    div_sel = SEL_W'(sel);
    exp_per = TCLK * (1 << sel);
    repeat (6) @(posedge clk);
    #2;
    drop_ready(seed);
    wait_words(TOTAL * (1 << sel) + 50);
    check_words("R4");
    check(rise_cnt == TOTAL, "R6", $sformatf("rising edges sel=%0d", sel), rise_cnt, TOTAL);
    check(first_rise_t - fall_t >= TCLK, "R3", "guard before first rise (ns)",
          longint'(first_rise_t - fall_t), longint'(TCLK));
    check(per_bad == 0, "R5", $sformatf("period errors sel=%0d", sel), per_bad, 0);
    check(ovr_n == 0, "R10", "no overrun on clean frame", ovr_n, 0);
  endtask

  task automatic t_level_hold();
    int r0, g0;
    r0 = rise_cnt;
    g0 = got_n;
    repeat (300) @(posedge clk);
    #2;
    check(rise_cnt == r0, "R2", "rises while ready held low", rise_cnt - r0, 0);
    check(got_n == g0, "R2", "words while ready held low", got_n - g0, 0);
    check(sclk == 1'b0, "R6", "sclk low between frames", sclk, 0);
    rdy_n = 1'b1;
    m_live = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic t_free_run(input int seed);
    int r0;
    free_run = 1'b1;
    div_sel = SEL_W'(3);
    exp_per = TCLK * 8;
    r0 = rise_cnt;
    repeat (40) @(posedge clk);
    check(rise_cnt - r0 >= 4, "R7", "sclk toggles between frames", rise_cnt - r0, 4);
    @(posedge sclk);
    #1;
    drop_ready(seed);
    wait_words(TOTAL * 8 + 50);
    check_words("R7");
    check(per_bad == 0, "R5", "free-run period errors", per_bad, 0);
    rdy_n = 1'b1;
    m_live = 1'b0;
    repeat (6) @(posedge clk);
    free_run = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic t_overrun();
    free_run = 1'b0;
    div_sel = SEL_W'(3);
    exp_per = TCLK * 8;
    ovr_n = 0;
    repeat (6) @(posedge clk);
    #2;
    drop_ready(11);
    for (int c = 0; c < 5000 && got_n < 2; c++) @(posedge clk);
    @(posedge sclk);
    #1;
    rdy_n = 1'b1;
    @(posedge sclk);
    #1;
    drop_ready(29);
    wait_words(TOTAL * 8 + 50);
    check(ovr_n == 1, "R10", "overrun pulses", ovr_n, 1);
    check_words("R10");
    rdy_n = 1'b1;
    m_live = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_stop_frame(0, 3);
    t_level_hold();
    t_stop_frame(1, 5);
    rdy_n = 1'b1;
    m_live = 1'b0;
    t_stop_frame(3, 7);
    rdy_n = 1'b1;
    m_live = 1'b0;
    t_free_run(13);
    t_overrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule